// File: doc/BRIEF.md
# Predicated Vector Floating-Point Compare Unit

This block compares two vector operands element by element as IEEE-754 binary numbers and builds a result predicate from the outcome. The vector length is a parameter (256 bits by default). Elements can be half, single or double precision. A governing predicate with one bit per vector byte decides which elements take part. A second output is a sticky invalid-operation flag, which records NaN exceptions raised by the active elements.

The caller presents the operands, the element size, the governing predicate and the operation code, all together with a one-cycle `start` pulse. On the following cycle `done` is high and the registered destination predicate is valid. The operation code is taken from two fields of the instruction word: a three-bit major field and a one-bit minor field. Unsupported codes and the byte element size are reported as illegal, and no result is written for them. The invalid flag stays set until the caller pulses `clr_invalid`.

Top module: `fpcmp_pred_unit`

## Requirements
- R1: The code {op_major, op_minor} selects the operation: 010/0 a>=b, 010/1 a>b, 011/0 a==b, 011/1 a!=b, 110/0 unordered, 110/1 |a|>=|b|, 111/1 |a|>|b|. Every other code, including 111/0, is illegal.
- R2: `elem_size` 01, 10 and 11 select 16, 32 and 64-bit elements. 00 (bytes) is illegal. On an illegal request `done` and `illegal` pulse together, and neither `dst_pred` nor `invalid_flag` changes.
- R3: An element of E bytes at index i is governed by `gov_pred[i*E]`, and its result is written to `dst_pred[i*E]`. All other destination bits are 0, whatever the governing predicate holds in those positions.
- R4: An element whose governing bit is 0 yields 0 and never raises the invalid flag, even when it holds a signaling NaN.
- R5: If either operand is a NaN, the pair is unordered. Unordered gives 1 for not-equal and for the unordered test, and 0 for the other five operations.
- R6: The four ordering operations (a>=b, a>b, |a|>=|b|, |a|>|b|) raise invalid when any active operand is a NaN, whether quiet or signaling.
- R7: Equal, not-equal and unordered raise invalid only for a signaling NaN. A signaling NaN has all exponent bits set, a nonzero fraction, and a fraction MSB of 0.
- R8: The magnitude operations ignore both sign bits and compare |a| against |b|.
- R9: +0 and -0 compare equal. Infinities order beyond every finite value. Subnormal operands are compared exactly, with no flush to zero.
- R10: `done` is high for exactly the one cycle after `start`, and the new `dst_pred` and `illegal` are visible in that cycle. `dst_pred` holds its value until the next legal request.
- R11: `invalid_flag` is the OR over all active lanes of each legal request, accumulated over time. It is cleared by `clr_invalid`, but a request that raises invalid in the same cycle as the clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; all operands are sampled in this cycle |
| elem_size | input | 2 | Element size code (00 illegal, 01 half, 10 single, 11 double) |
| op_major | input | 3 | Major operation field |
| op_minor | input | 1 | Minor operation field |
| vec_a | input | VLEN | First operand vector |
| vec_b | input | VLEN | Second operand vector |
| gov_pred | input | VLEN/8 | Governing predicate, one bit per byte |
| clr_invalid | input | 1 | Clears the sticky invalid flag |
| done | output | 1 | Result valid, one cycle after start |
| illegal | output | 1 | Request rejected (with done) |
| dst_pred | output | VLEN/8 | Destination predicate |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
In half precision, one vector holds pairs that are greater, equal and smaller, along with signed zeros, infinities against finite values, subnormals and negative pairs. All five plain operations run on this vector, which separates the ordering, equality and sign-magnitude paths. Mixed-sign pairs under the magnitude operations show that the sign bits are removed. Quiet and signaling NaNs placed in single lanes separate the quiet flavour from the signaling flavour through the invalid flag. The same NaNs in inactive lanes, governing predicates with odd-byte bits set, single and double precision runs, and illegal codes check bit placement, lane suppression and rejection.

// File: rtl/fpcmp_pkg.sv
// Shared types for the predicated floating-point compare unit.
// Assumes every module that names an operation imports this package.
package fpcmp_pkg;
    typedef enum logic [2:0] {
        CMP_GE  = 3'd0,
        CMP_GT  = 3'd1,
        CMP_EQ  = 3'd2,
        CMP_NE  = 3'd3,
        CMP_UO  = 3'd4,
        CMP_AGE = 3'd5,
        CMP_AGT = 3'd6
    } cmp_op_e;

    localparam int NUM_SIZES = 3;  // half, single, double
endpackage

// File: rtl/fpcmp_decode.sv
// Operation and size decode.
// Maps the instruction fields to an internal operation and a legality bit.
// Assumes nothing about timing; purely combinational.
module fpcmp_decode
    import fpcmp_pkg::*;
(
    input  logic [1:0] elem_size,
    input  logic [2:0] op_major,
    input  logic       op_minor,
    output cmp_op_e    op,
    output logic       legal
);
    logic code_ok;

    // Translate the four-bit code into an operation; flag unallocated codes.
    always_comb begin
        op      = CMP_GE;
        code_ok = 1'b1;
        unique case ({op_major, op_minor})
            4'b010_0: op = CMP_GE;
            4'b010_1: op = CMP_GT;
            4'b011_0: op = CMP_EQ;
            4'b011_1: op = CMP_NE;
            4'b110_0: op = CMP_UO;
            4'b110_1: op = CMP_AGE;
            4'b111_1: op = CMP_AGT;
            default:  code_ok = 1'b0;
        endcase
    end

    // Byte elements are not a floating-point format.
    assign legal = code_ok && (elem_size != 2'b00);
endmodule

// File: rtl/fpcmp_lane.sv
// One element comparator of width W with EW exponent bits.
// Evaluates only when active; an inactive lane yields 0 and no exception.
module fpcmp_lane
    import fpcmp_pkg::*;
#(
    parameter int W  = 16,
    parameter int EW = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  cmp_op_e      op,
    input  logic         active,
    output logic         res,
    output logic         inv
);
    localparam int FW = W - 1 - EW;

    logic nan_a, nan_b, snan_a, snan_b, unord;
    logic mag, signaling, sa, sb, both_zero, eq, gt, raw;
    logic [W-2:0] ma, mb;

    // Classify NaN operands.
    always_comb begin
        nan_a  = (&a[W-2 -: EW]) && (|a[FW-1:0]);
        nan_b  = (&b[W-2 -: EW]) && (|b[FW-1:0]);
        snan_a = nan_a && !a[FW-1];
        snan_b = nan_b && !b[FW-1];
        unord  = nan_a || nan_b;
    end

    // Sign-magnitude ordering with optional sign removal.
    always_comb begin
        mag       = (op == CMP_AGE) || (op == CMP_AGT);
        signaling = (op == CMP_GE) || (op == CMP_GT) || mag;
        sa        = a[W-1] && !mag;
        sb        = b[W-1] && !mag;
        ma        = a[W-2:0];
        mb        = b[W-2:0];
        both_zero = (ma == '0) && (mb == '0);
        eq        = both_zero || ((sa == sb) && (ma == mb));
        if (both_zero)     gt = 1'b0;
        else if (sa != sb) gt = sb;
        else if (!sa)      gt = ma > mb;
        else               gt = ma < mb;
    end

    // Select the relation and gate result and exception by the predicate.
    always_comb begin
        unique case (op)
            CMP_GE, CMP_AGE: raw = !unord && (gt || eq);
            CMP_GT, CMP_AGT: raw = !unord && gt;
            CMP_EQ:          raw = !unord && eq;
            CMP_NE:          raw = unord || !eq;
            default:         raw = unord;
        endcase
        res = active && raw;
        inv = active && (signaling ? unord : (snan_a || snan_b));
    end

    // Guard lane-level exception rules.
    always_comb begin
        if (!active) begin
            assert_inactive_silent_R4: assert (!res && !inv);
        end
        if (!signaling && !snan_a && !snan_b) begin
            assert_quiet_no_invalid_R7: assert (!inv);
        end
    end
endmodule

// File: rtl/fpcmp_lanes.sv
// A row of comparators for one element size of EB bytes.
// Places each result on the predicate bit of the element's lowest byte.
module fpcmp_lanes
    import fpcmp_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int EB   = 2
) (
    input  logic [VLEN-1:0]   a,
    input  logic [VLEN-1:0]   b,
    input  logic [VLEN/8-1:0] gov,
    input  cmp_op_e           op,
    output logic [VLEN/8-1:0] dst,
    output logic              inv_any
);
    localparam int NB    = VLEN / 8;
    localparam int W     = EB * 8;
    localparam int NEL   = NB / EB;
    localparam int EW    = (EB == 2) ? 5 : (EB == 4) ? 8 : 11;

    logic [NEL-1:0] res_v, inv_v;

    for (genvar i = 0; i < NEL; i++) begin : g_lane
        fpcmp_lane #(.W(W), .EW(EW)) u_lane (
            .a      (a[i*W +: W]),
            .b      (b[i*W +: W]),
            .op     (op),
            .active (gov[i*EB]),
            .res    (res_v[i]),
            .inv    (inv_v[i])
        );
    end

    // Scatter element results to byte-granular positions.
    always_comb begin
        dst = '0;
        for (int i = 0; i < NEL; i++) dst[i*EB] = res_v[i];
    end

    assign inv_any = |inv_v;
endmodule

// File: rtl/fpcmp_pred_unit.sv
// Predicated vector floating-point compare unit (top).
// Decodes the request, evaluates all three element sizes in parallel,
// selects one, and registers the predicate and sticky invalid flag.
// Assumes start is a single-cycle pulse with operands stable in that cycle.
module fpcmp_pred_unit
    import fpcmp_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        elem_size,
    input  logic [2:0]        op_major,
    input  logic              op_minor,
    input  logic [VLEN-1:0]   vec_a,
    input  logic [VLEN-1:0]   vec_b,
    input  logic [VLEN/8-1:0] gov_pred,
    input  logic              clr_invalid,
    output logic              done,
    output logic              illegal,
    output logic [VLEN/8-1:0] dst_pred,
    output logic              invalid_flag
);
    localparam int NB = VLEN / 8;

    cmp_op_e         op;
    logic            legal;
    logic [NB-1:0]   dst_w [NUM_SIZES];
    logic [NUM_SIZES-1:0] inv_w;
    logic [NB-1:0]   dst_sel;
    logic            inv_sel;

    fpcmp_decode u_dec (
        .elem_size (elem_size),
        .op_major  (op_major),
        .op_minor  (op_minor),
        .op        (op),
        .legal     (legal)
    );

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        fpcmp_lanes #(.VLEN(VLEN), .EB(2 << k)) u_row (
            .a       (vec_a),
            .b       (vec_b),
            .gov     (gov_pred),
            .op      (op),
            .dst     (dst_w[k]),
            .inv_any (inv_w[k])
        );
    end

    // Pick the row that matches the requested element size.
    always_comb begin
        unique case (elem_size)
            2'b01:   begin dst_sel = dst_w[0]; inv_sel = inv_w[0]; end
            2'b10:   begin dst_sel = dst_w[1]; inv_sel = inv_w[1]; end
            2'b11:   begin dst_sel = dst_w[2]; inv_sel = inv_w[2]; end
            default: begin dst_sel = '0;       inv_sel = 1'b0;     end
        endcase
    end

    // Result registers: handshake, predicate and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            illegal      <= 1'b0;
            dst_pred     <= '0;
            invalid_flag <= 1'b0;
        end else begin
            done    <= start;
            illegal <= start && !legal;
            if (start && legal) dst_pred <= dst_sel;
            invalid_flag <= (start && legal && inv_sel) ||
                            (invalid_flag && !clr_invalid);
        end
    end

    assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    assert_illegal_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);
    assert_illegal_keeps_dst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !legal) |=> $stable(dst_pred));
    assert_ungoverned_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && legal) |=> ((dst_pred & ~$past(gov_pred)) == '0));
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !clr_invalid) |=> invalid_flag);
endmodule

// File: tb/fpcmp_pred_unit_test.sv
module fpcmp_pred_unit_test;
    localparam int VLEN = 256;
    localparam int NB   = VLEN / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] elem_size = 2'b01;
    logic [2:0] op_major = 3'b010;
    logic op_minor = 1'b0;
    logic [VLEN-1:0] vec_a = '0, vec_b = '0;
    logic [NB-1:0] gov_pred = '0;
    logic clr_invalid = 1'b0;
    logic done, illegal, invalid_flag;
    logic [NB-1:0] dst_pred;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    fpcmp_pred_unit #(.VLEN(VLEN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_size(elem_size),
        .op_major(op_major), .op_minor(op_minor), .vec_a(vec_a), .vec_b(vec_b),
        .gov_pred(gov_pred), .clr_invalid(clr_invalid), .done(done),
        .illegal(illegal), .dst_pred(dst_pred), .invalid_flag(invalid_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] spread(input logic [31:0] ebits, input int eb);
        logic [NB-1:0] r = '0;
        for (int i = 0; i < NB / eb; i++) r[i*eb] = ebits[i];
        return r;
    endfunction

    task automatic clear_vecs();
        vec_a = '0; vec_b = '0;
    endtask
    task automatic set16(input int i, input logic [15:0] a, input logic [15:0] b);
        vec_a[i*16 +: 16] = a; vec_b[i*16 +: 16] = b;
    endtask
    task automatic set32(input int i, input logic [31:0] a, input logic [31:0] b);
        vec_a[i*32 +: 32] = a; vec_b[i*32 +: 32] = b;
    endtask
    task automatic set64(input int i, input logic [63:0] a, input logic [63:0] b);
        vec_a[i*64 +: 64] = a; vec_b[i*64 +: 64] = b;
    endtask

    // Issue one request at a falling edge; outputs are sampled at the next one.
    task automatic run(input logic [1:0] sz, input logic [3:0] code, input logic [NB-1:0] g);
        @(negedge clk);
        elem_size = sz; op_major = code[3:1]; op_minor = code[0];
        gov_pred = g; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); clr_invalid = 1'b1;
        @(negedge clk); clr_invalid = 1'b0;
        chk("R11 flag cleared", invalid_flag, 0);
    endtask

    localparam logic [3:0] C_GE = 4'b0100, C_GT = 4'b0101, C_EQ = 4'b0110,
                           C_NE = 4'b0111, C_UO = 4'b1100, C_AGE = 4'b1101,
                           C_AGT = 4'b1111;
    localparam logic [NB-1:0] ALL = '1;

    task automatic t_reset();
        chk("R10 reset done", done, 0);
        chk("R10 reset dst", dst_pred, 0);
        chk("R11 reset flag", invalid_flag, 0);
        chk("R2 reset illegal", illegal, 0);
    endtask

    task automatic t_half_basic();
        clear_vecs();
        set16(0, 16'h4000, 16'h3C00);  // 2 vs 1
        set16(1, 16'h3C00, 16'h3C00);  // 1 vs 1
        set16(2, 16'h3C00, 16'h4000);  // 1 vs 2
        set16(3, 16'h8000, 16'h0000);  // -0 vs +0
        set16(4, 16'h7C00, 16'h4000);  // +inf vs 2
        set16(5, 16'hFC00, 16'hBC00);  // -inf vs -1
        set16(6, 16'h0001, 16'h0002);  // subnormals
        set16(7, 16'hBC00, 16'hC000);  // -1 vs -2
        run(2'b01, C_GE, ALL);
        chk("R1 R9 half GE done", done, 1);
        chk("R1 R9 half GE", dst_pred, spread(32'hFF9B, 2));
        run(2'b01, C_GT, ALL);
        chk("R1 R9 half GT", dst_pred, spread(32'h0091, 2));
        run(2'b01, C_EQ, ALL);
        chk("R1 R9 half EQ", dst_pred, spread(32'hFF0A, 2));
        run(2'b01, C_NE, ALL);
        chk("R1 half NE", dst_pred, spread(32'h00F5, 2));
        run(2'b01, C_UO, ALL);
        chk("R1 half UO", dst_pred, 0);
        chk("R6 no NaN no flag", invalid_flag, 0);
        @(negedge clk);
        chk("R10 done one cycle", done, 0);
        chk("R10 dst held", dst_pred, 0);
    endtask

    task automatic t_magnitude();
        clear_vecs();
        set16(0, 16'hC000, 16'h3C00);  // -2 vs 1
        set16(1, 16'h3C00, 16'hBC00);  // 1 vs -1
        set16(2, 16'hBC00, 16'h4000);  // -1 vs 2
        run(2'b01, C_AGE, ALL);
        chk("R8 magnitude GE", dst_pred, spread(32'hFFFB, 2));
        run(2'b01, C_AGT, ALL);
        chk("R8 magnitude GT", dst_pred, spread(32'h0001, 2));
        run(2'b01, C_GE, ALL);
        chk("R8 signed GE differs", dst_pred, spread(32'hFFFA, 2));
    endtask

    task automatic t_nan();
        clear_vecs();
        set16(0, 16'h7E00, 16'h3C00);  // qNaN vs 1
        set16(1, 16'h3C00, 16'h7C01);  // 1 vs sNaN
        run(2'b01, C_EQ, ALL);
        chk("R5 EQ unordered", dst_pred, spread(32'hFFFC, 2));
        chk("R7 EQ sNaN raises", invalid_flag, 1);
        clear_flag();
        run(2'b01, C_NE, ALL);
        chk("R5 NE unordered", dst_pred, spread(32'h0003, 2));
        run(2'b01, C_UO, ALL);
        chk("R5 UO unordered", dst_pred, spread(32'h0003, 2));
        clear_flag();
        run(2'b01, C_GE, ALL);
        chk("R5 GE unordered", dst_pred, spread(32'hFFFC, 2));
        chk("R6 GE NaN raises", invalid_flag, 1);
        clear_flag();
        set16(1, 16'h3C00, 16'h3C00);  // only a quiet NaN remains
        run(2'b01, C_EQ, ALL);
        chk("R7 EQ qNaN result", dst_pred, spread(32'hFFFE, 2));
        chk("R7 EQ qNaN silent", invalid_flag, 0);
        run(2'b01, C_NE, ALL);
        chk("R7 NE qNaN silent", invalid_flag, 0);
        run(2'b01, C_AGT, ALL);
        chk("R6 AGT qNaN raises", invalid_flag, 1);
        clear_flag();
        run(2'b01, C_GT, ALL);
        chk("R6 GT qNaN raises", invalid_flag, 1);
        clear_flag();
    endtask

    task automatic t_predicate();
        clear_vecs();
        set16(0, 16'h7C01, 16'h3C00);  // sNaN in an inactive lane
        run(2'b01, C_GE, 32'hFFFF_FFFE);
        chk("R3 R4 odd bits ignored, lane0 off", dst_pred, spread(32'hFFFE, 2));
        chk("R4 inactive sNaN silent", invalid_flag, 0);
    endtask

    task automatic t_single();
        clear_vecs();
        set32(0, 32'h4000_0000, 32'h3F80_0000);  // 2 vs 1
        set32(1, 32'h3F80_0000, 32'h4000_0000);  // 1 vs 2
        set32(2, 32'h8000_0000, 32'h0000_0000);  // -0 vs +0
        set32(3, 32'h7FC0_0000, 32'h3F80_0000);  // qNaN vs 1
        run(2'b10, C_GT, ALL);
        chk("R3 single GT", dst_pred, spread(32'h01, 4));
        chk("R6 single qNaN raises", invalid_flag, 1);
        clear_flag();
        run(2'b10, C_UO, ALL);
        chk("R3 single UO bit12", dst_pred, 32'h0000_1000);
        run(2'b10, C_NE, ~32'h0000_1010);
        chk("R4 single NE lanes off", dst_pred, 32'h0000_0001);
        chk("R4 single no flag", invalid_flag, 0);
    endtask

    task automatic t_double();
        clear_vecs();
        set64(0, 64'hFFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000);  // -inf vs 1
        set64(1, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001);  // subnormals
        set64(2, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000);  // 2 vs 2
        set64(3, 64'h7FF0_0000_0000_0001, 64'h0000_0000_0000_0000);  // sNaN vs 0
        run(2'b11, C_GE, ALL);
        chk("R9 double GE", dst_pred, spread(32'h6, 8));
        chk("R6 double sNaN raises", invalid_flag, 1);
        clear_flag();
        run(2'b11, C_EQ, ALL);
        chk("R9 double EQ", dst_pred, spread(32'h4, 8));
        chk("R7 double sNaN raises", invalid_flag, 1);
        clear_flag();
    endtask

    task automatic t_illegal();
        logic [NB-1:0] held;
        held = dst_pred;
        clear_vecs();
        set16(0, 16'h7C01, 16'h7C01);
        run(2'b00, C_NE, ALL);
        chk("R2 byte size illegal", illegal, 1);
        chk("R2 byte size done", done, 1);
        chk("R2 dst unchanged", dst_pred, held);
        chk("R2 flag unchanged", invalid_flag, 0);
        run(2'b01, 4'b1110, ALL);
        chk("R1 code 111/0 illegal", illegal, 1);
        chk("R1 code 111/0 dst held", dst_pred, held);
        run(2'b01, 4'b0000, ALL);
        chk("R1 code 000/0 illegal", illegal, 1);
        run(2'b01, C_NE, ALL);
        chk("R1 legal clears illegal", illegal, 0);
        clear_flag();
    endtask

    task automatic t_sticky();
        clear_vecs();
        set16(0, 16'h7C01, 16'h0000);
        run(2'b01, C_EQ, ALL);
        chk("R11 set", invalid_flag, 1);
        clear_vecs();
        run(2'b01, C_EQ, ALL);
        chk("R11 stays set", invalid_flag, 1);
        set16(0, 16'h7C01, 16'h0000);
        @(negedge clk);
        elem_size = 2'b01; op_major = 3'b011; op_minor = 1'b0;
        gov_pred = ALL; start = 1'b1; clr_invalid = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_invalid = 1'b0;
        chk("R11 set beats clear", invalid_flag, 1);
        clear_flag();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_half_basic();
        t_magnitude();
        t_nan();
        t_predicate();
        t_single();
        t_double();
        t_illegal();
        t_sticky();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule